// File: doc/BRIEF.md
# Serial gain word loader

This block takes an 8-bit gain word from a three-wire serial link (data, serial clock and an active-low load enable) and holds the word that sets an attenuator or gain core. The serial pins are asynchronous to the block's fast system clock. Each pin passes through a two-flop synchronizer, and edges are found on the system clock. The system clock must run at least four times faster than the serial clock.

While the enable is low, the link fills a shift register, most significant bit first. Each bit goes through a master stage on the rising serial clock edge and into the shift register on the falling edge that follows. When the enable goes high, the shift register is committed to the active gain register and further shifting is blocked. A one-cycle pulse marks every change of the active gain.

Two static control inputs, a power-on input and a wake input, are synchronized in the same way. Both must be high before the output-enable flag is set.

Top module: `gain_word_loader`

## Requirements
- R1: While reset is asserted and right after it is released, `gain` is 0x00, `gain_upd` is 0 and `out_en` is 0. The synchronized enable starts in its high (idle) state.
- R2: After the enable has been low and exactly 8 bits have been clocked in, a rising edge on `ser_en_n` makes `gain` hold the word. The first bit sent lands in bit 7 and the last bit sent lands in bit 0.
- R3: `gain` changes only in response to a low-to-high transition of `ser_en_n`. The new value appears on the third system clock edge after the edge that first samples `ser_en_n` high. While the enable is low, `gain` keeps its previous value however many bits are shifted.
- R4: A bit is captured on a rising serial clock edge and enters the shift register on the next falling edge. A falling edge with no captured rising edge after the enable went low shifts nothing.
- R5: Serial clock edges that arrive while `ser_en_n` is high are ignored. The shift register keeps its contents, so a later commit without new bits reproduces the previously shifted word.
- R6: When more than 8 bits are shifted in one enable-low window, `gain` takes the last 8 bits sent on commit.
- R7: `gain_upd` is high for exactly one system clock cycle, in the same cycle that `gain` takes a new value that differs from the old one. A commit that leaves `gain` unchanged produces no pulse.
- R8: `out_en` is 1 only when both `pwr_on` and `wake` are 1. It follows changes of those inputs two system clock edges after the edge that first samples them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first, asynchronous |
| ser_en_n | input | 1 | Active-low load enable; rising edge commits the word |
| pwr_on | input | 1 | 1 = powered, 0 = powered down |
| wake | input | 1 | 1 = normal operation, 0 = low-power sleep |
| gain | output | 8 | Active gain word |
| gain_upd | output | 1 | One-cycle pulse when `gain` changes |
| out_en | output | 1 | Output stage enable |

## Verification
The bench targets several corner cases. The first is an enable that drops while the serial clock is already high. A design that shifts on that orphan falling edge would pull a stale master bit into the word. The second is serial clock activity during the enable-high window. A design that does not gate those edges would corrupt the word that a bare enable-low/high pulse recommits. The bench also sends an over-long 12-bit burst, which a wrong shift direction or bit order would truncate into the wrong byte. It recommits an unchanged word to catch a spurious update pulse. Finally, it drives all four combinations of the power and wake inputs, to catch a flag that follows only one of them.

// File: rtl/gwl_pkg.sv
package gwl_pkg;
  parameter int GAIN_W      = 8;
  parameter int SYNC_STAGES = 2;

  typedef logic [GAIN_W-1:0] gain_t;

  // append one bit at the LSB end; earlier bits move toward the MSB
  function automatic gain_t shift_in(input gain_t word, input logic bit_in);
    return {word[GAIN_W-2:0], bit_in};
  endfunction

  // a commit only signals an update when the word really changes
  function automatic logic word_changed(input gain_t old_w, input gain_t new_w);
    return (old_w != new_w);
  endfunction
endpackage

// File: rtl/gwl_sync.sv
module gwl_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
        else        chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gwl_edge.sv
module gwl_edge #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_det
      assign rise[b] =  lvl[b] & ~prev[b];
      assign fall[b] = ~lvl[b] &  prev[b];
    end
  endgenerate
endmodule

// File: rtl/gwl_shifter.sv
module gwl_shifter
  import gwl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_n_lvl,
  input  logic  en_fall,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  sdata,
  output gain_t shreg,
  output logic  capture_evt,
  output logic  shift_evt
);
  logic master;
  logic mvalid;

  assign capture_evt = sclk_rise & ~en_n_lvl;
  assign shift_evt   = sclk_fall & ~en_n_lvl & mvalid;

  // master stage: sampled on rising serial clock while loading
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      mvalid <= 1'b0;
    end else if (en_n_lvl) begin
      mvalid <= 1'b0;
    end else if (en_fall) begin
      master <= 1'b0;
      mvalid <= 1'b0;
    end else if (capture_evt) begin
      master <= sdata;
      mvalid <= 1'b1;
    end else if (shift_evt) begin
      mvalid <= 1'b0;
    end
  end

  // slave stage: the shift register proper
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (shift_evt) shreg <= shift_in(shreg, master);
  end

  AST_NO_SHIFT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_lvl |=> $stable(shreg)); // R5
  AST_SHIFT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(shreg)); // R4
  AST_NO_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_lvl |-> !capture_evt && !shift_evt); // R5
endmodule

// File: rtl/gwl_gain_reg.sv
module gwl_gain_reg
  import gwl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  commit,
  input  gain_t next_word,
  output gain_t gain,
  output logic  upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (commit) begin
        gain <= next_word;
        upd  <= word_changed(gain, next_word);
      end
    end
  end

  AST_GAIN_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(gain)); // R3
  AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (gain != $past(gain))); // R7
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd); // R7
endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader
  import gwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en_n,
  input  logic              pwr_on,
  input  logic              wake,
  output logic [GAIN_W-1:0] gain,
  output logic              gain_upd,
  output logic              out_en
);
  // serial group: {enable_n, data, clock}; enable resets high (idle)
  localparam logic [2:0] SER_RST = 3'b100;

  logic [2:0] ser_s;
  logic [1:0] ctl_s;
  logic [1:0] edge_rise, edge_fall;
  logic       sclk_rise, sclk_fall, en_rise, en_fall;
  logic       capture_evt, shift_evt;
  gain_t      shreg;

  gwl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SER_RST)) i_ser_sync (
    .clk(clk), .rst_n(rst_n), .din({ser_en_n, ser_data, ser_clk}), .dout(ser_s));

  gwl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) i_ctl_sync (
    .clk(clk), .rst_n(rst_n), .din({wake, pwr_on}), .dout(ctl_s));

  gwl_edge #(.WIDTH(2), .RST_VAL(2'b10)) i_edge (
    .clk(clk), .rst_n(rst_n), .lvl({ser_s[2], ser_s[0]}),
    .rise(edge_rise), .fall(edge_fall));

  assign sclk_rise = edge_rise[0];
  assign sclk_fall = edge_fall[0];
  assign en_rise   = edge_rise[1];
  assign en_fall   = edge_fall[1];

  gwl_shifter i_shifter (
    .clk(clk), .rst_n(rst_n), .en_n_lvl(ser_s[2]), .en_fall(en_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdata(ser_s[1]),
    .shreg(shreg), .capture_evt(capture_evt), .shift_evt(shift_evt));

  gwl_gain_reg i_gain (
    .clk(clk), .rst_n(rst_n), .commit(en_rise), .next_word(shreg),
    .gain(gain), .upd(gain_upd));

  assign out_en = ctl_s[0] & ctl_s[1];

  AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> ($past(pwr_on, 2) && $past(wake, 2))); // R8
  AST_COMMIT_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |-> !shift_evt && !capture_evt); // R3
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (gain == '0) && !gain_upd && !out_en); // R1
endmodule

// File: tb/test_gain_word_loader.sv
`timescale 1ns/1ps
module test_gain_word_loader;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_en_n = 1, pwr_on = 0, wake = 0;
  logic [7:0] gain;
  logic gain_upd, out_en;
  int checks = 0, fails = 0, upd_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  gain_word_loader i_gain_word_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en_n(ser_en_n), .pwr_on(pwr_on), .wake(wake),
    .gain(gain), .gain_upd(gain_upd), .out_en(out_en));

  // behavioural reference: pin history, index 0 = most recent sample
  int h_clk[3], h_dat[3], h_en[3], h_pwr[3], h_wk[3];
  int m_shreg, m_master, m_mvalid, m_gain, m_upd, m_oe;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        h_clk[i] = 0; h_dat[i] = 0; h_en[i] = 1; h_pwr[i] = 0; h_wk[i] = 0;
      end
      m_shreg = 0; m_master = 0; m_mvalid = 0; m_gain = 0; m_upd = 0; m_oe = 0;
    end else begin
      m_upd = 0;
      if (h_en[1] == 1 && h_en[2] == 0) begin
        if (m_shreg != m_gain) m_upd = 1;
        m_gain = m_shreg;
      end
      if (h_en[1] == 1) m_mvalid = 0;
      else if (h_en[2] == 1) m_mvalid = 0;
      else if (h_clk[1] == 1 && h_clk[2] == 0) begin
        m_master = h_dat[1]; m_mvalid = 1;
      end else if (h_clk[1] == 0 && h_clk[2] == 1 && m_mvalid == 1) begin
        m_shreg = ((m_shreg << 1) | m_master) & 255; m_mvalid = 0;
      end
      for (int i = 2; i > 0; i--) begin
        h_clk[i] = h_clk[i-1]; h_dat[i] = h_dat[i-1]; h_en[i] = h_en[i-1];
        h_pwr[i] = h_pwr[i-1]; h_wk[i] = h_wk[i-1];
      end
      h_clk[0] = ser_clk; h_dat[0] = ser_data; h_en[0] = ser_en_n;
      h_pwr[0] = pwr_on; h_wk[0] = wake;
      m_oe = h_pwr[1] & h_wk[1];
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 gain vs model", gain, m_gain);
      chk("R7 gain_upd vs model", gain_upd, m_upd);
      chk("R8 out_en vs model", out_en, m_oe);
      if (gain_upd) upd_cnt++;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int word, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = (word >> i) & 1; hold(4);
      ser_clk = 1; hold(4);
      ser_clk = 0; hold(4);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    hold(1);
    chk("R1 gain in reset", gain, 0);
    chk("R1 gain_upd in reset", gain_upd, 0);
    chk("R1 out_en in reset", out_en, 0);
    hold(4); rst_n = 1; hold(2);
    chk("R1 gain after reset", gain, 0);
    chk("R1 out_en after reset", out_en, 0);

    // R8: all four combinations
    pwr_on = 1; wake = 0; hold(4); chk("R8 pwr only", out_en, 0);
    pwr_on = 0; wake = 1; hold(4); chk("R8 wake only", out_en, 0);
    pwr_on = 0; wake = 0; hold(4); chk("R8 neither", out_en, 0);
    pwr_on = 1; wake = 1; hold(4); chk("R8 both", out_en, 1);

    // R2: plain 8-bit load, MSB first
    upd_cnt = 0;
    ser_en_n = 0; hold(4); send(8'hA5, 8); ser_en_n = 1; hold(6);
    chk("R2 load A5", gain, 8'hA5);
    chk("R7 one pulse on change", upd_cnt, 1);

    // R3: gain holds while shifting
    ser_en_n = 0; hold(4); send(4'h3, 4);
    chk("R3 hold mid-shift", gain, 8'hA5);
    send(4'hC, 4);
    chk("R3 hold before commit", gain, 8'hA5);
    ser_en_n = 1; hold(2);
    chk("R3 not yet at edge 2", gain, 8'hA5);
    hold(1);
    chk("R3 committed at edge 3", gain, 8'h3C);
    hold(3);

    // R6: over-long burst keeps last eight
    ser_en_n = 0; hold(4); send(12'hE81, 12); ser_en_n = 1; hold(6);
    chk("R6 last eight bits", gain, 8'h81);

    // R5: clocks while idle ignored, recommit gives same word, no pulse
    upd_cnt = 0; ser_data = 1;
    for (int k = 0; k < 5; k++) begin ser_clk = 1; hold(4); ser_clk = 0; hold(4); end
    ser_en_n = 0; hold(6); ser_en_n = 1; hold(6);
    chk("R5 idle clocks ignored", gain, 8'h81);
    chk("R7 no pulse on same word", upd_cnt, 0);

    // R4: orphan falling edge after enable drops while clock high
    ser_data = 1; ser_clk = 1; hold(6);
    ser_en_n = 0; hold(6);
    ser_clk = 0; hold(6);
    send(4'h6, 4); ser_en_n = 1; hold(6);
    chk("R4 orphan fall not shifted", gain, 8'h16);

    // R7: recommit unchanged word
    upd_cnt = 0;
    ser_en_n = 0; hold(6); ser_en_n = 1; hold(6);
    chk("R7 recommit no pulse", upd_cnt, 0);
    chk("R7 recommit keeps gain", gain, 8'h16);

    hold(4);
    finish_up();
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule